// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive approximation converter. It drives a registered trial code to an external DAC and comparator, and it reads back a single decision bit, `cmp_above`. That bit is high when the sampled analog input is strictly greater than the trial code. A one-cycle `start` pulse begins a conversion. The block then tests one bit per clock, from the most significant to the least significant. It keeps each bit when the comparator reports the input above the trial, and it clears the bit otherwise.

After the last bit is decided, the block raises `done` for one cycle and presents the final code on `result`. It also streams each decided bit on `ser_bit` with a `ser_valid` strobe, most significant bit first, in the cycle after that bit is decided. With the default `WIDTH` of 10, one LSB is 1/1024 of the reference.

The controller has two states:
- `ST_IDLE` waits for `start`.
- `ST_TEST` runs one decision per clock.

It has three transitions:
- IDLE→TEST when `start` is accepted.
- TEST→TEST while lower bits remain.
- TEST→IDLE after bit 0 is decided.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `trial_code`, `result`, `busy`, `done`, `ser_bit` and `ser_valid` are all 0.
- R2: A `start` sampled high in ST_IDLE moves the block to ST_TEST at that edge. From then on `busy` is 1 and `trial_code` holds only bit WIDTH-1 set.
- R3: While bit p is under test, `trial_code` equals the bits already kept above p, plus bit p set, plus zeros below p. Bit p is kept at 1 when `cmp_above` is 1 at the deciding edge, and cleared otherwise. For example, with WIDTH=10 and an input of 614, the trials are 512, 768, 640 and 576, and the first four decisions are 1, 0, 0, 1.
- R4: A conversion takes exactly WIDTH decision edges after the start edge. `done` is high for exactly one cycle, after the WIDTH-th decision edge, and in the cycle after that `busy` is 0.
- R5: The cycle in which `done` is high shows the final code on `result`. `result` changes at no other time except reset. With a comparator that reports input > trial, the final code for input v is v-1, or 0 when v is 0.
- R6: After each decision edge, `ser_valid` is 1 for one cycle and `ser_bit` carries the bit just decided. The bits come MSB first, WIDTH strobes per conversion, and `ser_valid` is 0 at all other times.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running conversion finishes on its original schedule with its original result, and no second conversion follows.
- R8: Reset during a conversion returns the block to ST_IDLE with all outputs cleared. A later start then converts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion; honoured only when idle |
| cmp_above | input | 1 | Comparator decision: input above the current trial code |
| trial_code | output | WIDTH | Registered code driven to the external DAC |
| busy | output | 1 | High while in ST_TEST |
| done | output | 1 | One-cycle pulse at the end of a conversion |
| result | output | WIDTH | Final code, held between conversions |
| ser_bit | output | 1 | Most recently decided bit |
| ser_valid | output | 1 | Qualifies `ser_bit` |

## Verification
The bench converts every input code from 0 to 1023 at the default width. A behavioural comparator models input > trial, so every trial sequence, serial stream and final code is checked against values worked out arithmetically.

The endpoints test different things. Input 0 clears every bit, and input 1023 keeps all bits but the last, so together they show that the keep and clear decisions are not swapped or stuck. Input 614 checks the documented four-step trial sequence.

A start issued mid-conversion and a reset issued mid-conversion show that the schedule cannot be restarted or corrupted, and that recovery leaves a clean idle state.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_TEST = 1'b1
    } sar_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    output logic                           busy,
    output logic                           load,
    output logic                           decide,
    output logic                           last,
    output logic [idx_width(WIDTH)-1:0]    bit_idx,
    output logic                           done
);

    localparam int unsigned IW = idx_width(WIDTH);
    localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);

    sar_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_TEST;
            ST_TEST: if (bit_idx == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy   = (state_q == ST_TEST);
    assign load   = (state_q == ST_IDLE) && start;
    assign decide = busy;
    assign last   = busy && (bit_idx == '0);

    // outputs: bit pointer and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= last;
            if (load)
                bit_idx <= TOP_IDX;
            else if (decide && !last)
                bit_idx <= bit_idx - 1'b1;
        end
    end

    // checker-side cycle counter, independent of bit_idx
    logic [IW:0] chk_cycles;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       chk_cycles <= '0;
        else if (load)    chk_cycles <= '0;
        else if (busy)    chk_cycles <= chk_cycles + 1'b1;
    end

    AST_LOAD_ENTERS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy && bit_idx == TOP_IDX); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> busy && bit_idx == $past(bit_idx) - 1'b1); // R7
    AST_DONE_AFTER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> chk_cycles == (IW+1)'(WIDTH)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic                           decide,
    input  logic                           last,
    input  logic [idx_width(WIDTH)-1:0]    bit_idx,
    input  logic                           cmp_above,
    output logic [WIDTH-1:0]               trial_code,
    output logic [WIDTH-1:0]               result,
    output logic                           bit_kept
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] MSB_ONLY = ONE << (WIDTH - 1);

    logic [WIDTH-1:0] weight;
    logic [WIDTH-1:0] kept_code;
    logic [WIDTH-1:0] next_weight;

    always_comb begin
        weight      = ONE << bit_idx;
        next_weight = weight >> 1;
        bit_kept    = cmp_above;
        kept_code   = cmp_above ? trial_code : (trial_code & ~weight);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_code <= '0;
            result     <= '0;
        end else begin
            if (load)
                trial_code <= MSB_ONLY;
            else if (decide && !last)
                trial_code <= kept_code | next_weight;
            else if (decide)
                trial_code <= kept_code;
            if (decide && last)
                result <= kept_code;
        end
    end

    AST_TRIAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> trial_code[bit_idx] && ((trial_code & (weight - ONE)) == '0)); // R3
    AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(last)); // R5

endmodule

// File: rtl/sar_serializer.sv
module sar_serializer (
    input  logic clk,
    input  logic rst_n,
    input  logic decide,
    input  logic bit_kept,
    output logic ser_bit,
    output logic ser_valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_bit   <= 1'b0;
            ser_valid <= 1'b0;
        end else begin
            ser_valid <= decide;
            ser_bit   <= decide ? bit_kept : 1'b0;
        end
    end

    AST_SER_FOLLOWS_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(decide)); // R6
    AST_SER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_bit); // R6

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] trial_code,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             ser_bit,
    output logic             ser_valid
);

    localparam int unsigned IW = idx_width(WIDTH);

    logic          load;
    logic          decide;
    logic          last;
    logic          bit_kept;
    logic [IW-1:0] bit_idx;

    sar_seq #(.WIDTH(WIDTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .load    (load),
        .decide  (decide),
        .last    (last),
        .bit_idx (bit_idx),
        .done    (done)
    );

    sar_code_reg #(.WIDTH(WIDTH)) u_code (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .decide     (decide),
        .last       (last),
        .bit_idx    (bit_idx),
        .cmp_above  (cmp_above),
        .trial_code (trial_code),
        .result     (result),
        .bit_kept   (bit_kept)
    );

    sar_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .decide    (decide),
        .bit_kept  (bit_kept),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !$past(busy) |-> !ser_valid); // R8

endmodule

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] vin = '0;
    logic         cmp_above;
    logic [W-1:0] trial_code;
    logic         busy, done, ser_bit, ser_valid;
    logic [W-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    // behavioural comparator: input strictly above trial
    assign cmp_above = (vin > trial_code);

    sar_conv_ctrl #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
        .trial_code(trial_code), .busy(busy), .done(done), .result(result),
        .ser_bit(ser_bit), .ser_valid(ser_valid)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int v);
        return (v == 0) ? 0 : v - 1;
    endfunction

    function automatic int exp_trial(input int v, input int k);
        int p = W - 1 - k;
        int e = exp_code(v);
        return ((e >> (p + 1)) << (p + 1)) | (1 << p);
    endfunction

    // one conversion; optionally pulses start mid-run
    task automatic run_conv(input int v, input bit poke);
        int e = exp_code(v);
        int bad_trial = -1, bad_trial_exp = 0;
        int bad_ser = -1, bad_ser_exp = 0;
        int bad_done = -1;
        vin = W'(v);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2 busy after start", busy == 1'b1, busy, 1);
        for (int k = 0; k < W; k++) begin
            if (trial_code != W'(exp_trial(v, k)) && bad_trial < 0) begin
                bad_trial = trial_code; bad_trial_exp = exp_trial(v, k);
            end
            if (poke && k == 3) start = 1'b1;
            @(negedge clk) start = 1'b0;
            if ((!ser_valid || ser_bit != e[W-1-k]) && bad_ser < 0) begin
                bad_ser = {ser_valid, ser_bit}; bad_ser_exp = {1'b1, e[W-1-k]};
            end
            if (done != (k == W - 1) && bad_done < 0) bad_done = k;
        end
        check("R3 trial sequence", bad_trial < 0, bad_trial, bad_trial_exp);
        check("R6 serial stream", bad_ser < 0, bad_ser, bad_ser_exp);
        check("R4 done timing", bad_done < 0, bad_done, -1);
        check("R5 final code", result == W'(e), result, e);
        @(negedge clk);
        check("R4 single pulse and idle", !done && !busy && !ser_valid,
              {done, busy, ser_valid}, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1 reset outputs", trial_code == 0 && result == 0 && !busy && !done
              && !ser_valid && !ser_bit, trial_code, 0);
        @(negedge clk) rst_n = 1'b1;
        check("R1 after release", trial_code == 0 && result == 0 && !busy && !done
              && !ser_valid, {busy, done, ser_valid}, 0);

        // R3: documented example 614 -> trials 512,768,640,576 decisions 1,0,0,1
        vin = W'(614);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2 MSB-only first trial", trial_code == 512, trial_code, 512);
        @(negedge clk);
        check("R3 example bit9", ser_bit == 1'b1 && trial_code == 768, trial_code, 768);
        @(negedge clk);
        check("R3 example bit8", ser_bit == 1'b0 && trial_code == 640, trial_code, 640);
        @(negedge clk);
        check("R3 example bit7", ser_bit == 1'b0 && trial_code == 576, trial_code, 576);
        @(negedge clk);
        check("R3 example bit6", ser_bit == 1'b1, ser_bit, 1);
        repeat (W - 3) @(negedge clk);
        check("R5 example code", result == 613 && !busy, result, 613);

        // R5: result holds while idle
        repeat (4) @(negedge clk);
        check("R5 result held", result == 613 && !ser_valid, result, 613);

        // endpoints
        run_conv(0, 1'b0);
        run_conv(1023, 1'b0);

        // R7: start while busy ignored
        run_conv(300, 1'b1);
        repeat (W + 2) @(negedge clk);
        check("R7 no second conversion", result == 299 && !busy, result, 299);

        // R8: reset mid-conversion
        vin = W'(777);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid-run reset", !busy && result == 0 && trial_code == 0 && !ser_valid,
              {busy, ser_valid}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle after reset", !busy && !done, busy, 0);
        run_conv(777, 1'b0);

        // exhaustive sweep of every input code
        for (int v = 0; v < (1 << W); v++) run_conv(v, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule